// File: doc/BRIEF.md
# Boot ROM Read Guard with Replay Latch

This block sits in front of a 16 KB boot ROM and decides, for every read, whether the requester may see fresh ROM contents. The decision uses the program-counter value that comes with the request. While that value points inside the ROM, the read is served from the addressed location, and the block records which ROM word was fetched. When the program counter points anywhere else, the block does not reveal the requested location. It replays the word it last fetched legally instead, rotated to the byte lane that the request selects and cut to the access size.

Requests carry an address inside the ROM window, an access size and the program counter. Data comes back in the cycle after the strobe. A second, side-effect-free port serves debug reads. It answers exactly as a normal read would, but it never moves the replay latch. The ROM is a plain synthesizable word array. A preload port fills it one word at a time before use. Requests flagged as writes reach the block but have no effect.

Top module: `bootrom_guard`

## Requirements
- R1: A read with `rd_pc` below 0x4000 returns the little-endian data at the size-aligned address, zero-extended to 32 bits, with `rd_valid` high in the cycle after the strobe.
- R2: Size encoding is 2'b00 byte, 2'b01 halfword, 2'b10 word, and 2'b11 is handled as a word. A permitted word read ignores address bits [1:0]. A permitted halfword read ignores bit 0 and returns bytes 2–3 of the word when bit 1 is set. A permitted byte read returns byte `addr[1:0]` of the word.
- R3: A permitted read records the ROM word it fetched (address bits [13:2]) in the replay latch. A denied read leaves the latch unchanged.
- R4: A read with `rd_pc` at or above 0x4000 returns the 32-bit ROM word named by the replay latch. The word is rotated right by 8×(addr&3) bits for a byte access, by 8×(addr&2) bits for a halfword access, and not at all for a word access, then truncated to the access size.
- R5: After reset, `rd_valid` and `dbg_valid` are low, both data outputs are zero, and the replay latch names ROM word 0.
- R6: A debug read returns what a normal read with the same address, size, program counter and latch state would return, with `dbg_valid` high the next cycle. It never changes the replay latch.
- R7: A request with `rd_we` high produces no `rd_valid` pulse, leaves `rd_data` and the replay latch unchanged, and does not alter the ROM contents.
- R8: `rd_valid` is high only in the cycle after an accepted read, and `rd_data` holds its value until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_en | input | 1 | Preload strobe for one ROM word |
| fill_idx | input | 12 | Word index being preloaded |
| fill_word | input | 32 | Word value being preloaded |
| rd_en | input | 1 | Request strobe |
| rd_we | input | 1 | Request is a write (ignored) |
| rd_addr | input | 14 | Byte address inside the ROM |
| rd_size | input | 2 | Access size (00 byte, 01 half, 10/11 word) |
| rd_pc | input | 32 | Program counter of the requester |
| rd_valid | output | 1 | Read data valid (cycle after strobe) |
| rd_data | output | 32 | Read data, zero-extended |
| dbg_en | input | 1 | Debug read strobe |
| dbg_addr | input | 14 | Debug byte address |
| dbg_size | input | 2 | Debug access size |
| dbg_pc | input | 32 | Program counter used for the debug check |
| dbg_valid | output | 1 | Debug data valid |
| dbg_data | output | 32 | Debug read data |

## Verification
The bench targets the edges of the program-counter check. It uses 0x3FFF and 0x4000 as well as very large values. A design with an off-by-one or a truncated comparison would leak fresh data, or lock out a legal fetch. The bench also targets denied halfword reads at odd addresses, where a design that rotated by the full low two bits would return a mis-shifted half. It checks denied reads straight after reset, which must replay word 0. It checks debug reads and write-flagged requests placed between a legal fetch and a denied read, so a design that let either of them move the latch would replay the wrong word. Unaligned permitted reads of every size check that the lane is chosen from the aligned address.

// File: rtl/bootguard_pkg.sv
// Package: shared constants, access-size encoding and lane helper for the
// boot ROM read guard. Assumes a byte-addressed ROM built from 32-bit words.
package bootguard_pkg;

    localparam int PC_W   = 32;
    localparam int WORD_W = 32;

    // Access size carried with every request
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    // Byte lane a request selects: also the right-rotate amount in bytes
    function automatic logic [1:0] lane_of(input logic [1:0] addr_lo, input acc_size_e sz);
        case (sz)
            SZ_BYTE: return addr_lo;
            SZ_HALF: return {addr_lo[1], 1'b0};
            default: return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/bootrom_store.sv
// Module: word array holding the boot ROM image, with a preload write port
// and a parameterized number of synchronous read ports. Assumes preload and
// a read of the same word are never issued in one cycle.
module bootrom_store #(
    parameter int DEPTH  = 4096,
    parameter int IDX_W  = 12,
    parameter int DATA_W = 32,
    parameter int PORTS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_word,
    input  logic              rd_en   [PORTS],
    input  logic [IDX_W-1:0]  rd_idx  [PORTS],
    output logic [DATA_W-1:0] rd_word [PORTS]
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Preload one word of the image
    always_ff @(posedge clk) begin
        if (fill_en) mem[fill_idx] <= fill_word;
    end

    // One registered read per port
    for (genvar p = 0; p < PORTS; p++) begin : g_rport
        always_ff @(posedge clk) begin
            if (!rst_n)         rd_word[p] <= '0;
            else if (rd_en[p])  rd_word[p] <= mem[rd_idx[p]];
        end
    end

endmodule

// File: rtl/bootrom_req_decode.sv
// Module: per-request permission check and word selection. A request is
// permitted when its program counter lies below the ROM size; permitted
// requests use their own word, denied ones the latched word. Alignment is
// implicit: it never changes the word index, only the lane.
module bootrom_req_decode
    import bootguard_pkg::*;
#(
    parameter int ROM_BYTES = 16384,
    parameter int ROM_AW    = 14,
    parameter int WORD_AW   = 12
) (
    input  logic [ROM_AW-1:0]  addr,
    input  logic [1:0]         size,
    input  logic [PC_W-1:0]    pc,
    input  logic [WORD_AW-1:0] latch_idx,
    output logic               permit,
    output logic [WORD_AW-1:0] word_idx,
    output logic [1:0]         lane
);

    // Permission, word choice and lane for one request
    always_comb begin
        permit   = (pc < PC_W'(ROM_BYTES));
        word_idx = permit ? addr[ROM_AW-1:2] : latch_idx;
        lane     = lane_of(addr[1:0], acc_size_e'(size));
    end

endmodule

// File: rtl/bootrom_lane_fmt.sv
// Module: turns a fetched word into response data: right-rotate by the lane,
// then keep only the bits of the access size (zero-extended).
module bootrom_lane_fmt
    import bootguard_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        lane,
    input  logic [1:0]        size,
    output logic [WORD_W-1:0] data
);

    logic [WORD_W-1:0] rotated;

    // Rotate and truncate to the access width
    always_comb begin
        case (lane)
            2'd1:    rotated = {word[7:0],  word[31:8]};
            2'd2:    rotated = {word[15:0], word[31:16]};
            2'd3:    rotated = {word[23:0], word[31:24]};
            default: rotated = word;
        endcase
        case (acc_size_e'(size))
            SZ_BYTE: data = {24'd0, rotated[7:0]};
            SZ_HALF: data = {16'd0, rotated[15:0]};
            default: data = rotated;
        endcase
    end

endmodule

// File: rtl/bootrom_guard.sv
// Module: top of the boot ROM read guard. Port 0 is the requester (reads
// and ignored writes), port 1 the side-effect-free debug reader. Only a
// permitted requester read moves the replay latch. Response appears the
// cycle after the strobe and holds until the next read on that port.
module bootrom_guard
    import bootguard_pkg::*;
#(
    parameter int ROM_BYTES = 16384,
    localparam int ROM_AW   = $clog2(ROM_BYTES),
    localparam int WORD_AW  = ROM_AW - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_en,
    input  logic [WORD_AW-1:0] fill_idx,
    input  logic [WORD_W-1:0]  fill_word,
    input  logic               rd_en,
    input  logic               rd_we,
    input  logic [ROM_AW-1:0]  rd_addr,
    input  logic [1:0]         rd_size,
    input  logic [PC_W-1:0]    rd_pc,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data,
    input  logic               dbg_en,
    input  logic [ROM_AW-1:0]  dbg_addr,
    input  logic [1:0]         dbg_size,
    input  logic [PC_W-1:0]    dbg_pc,
    output logic               dbg_valid,
    output logic [WORD_W-1:0]  dbg_data
);

    localparam int NPORT  = 2;
    localparam int P_CPU  = 0;
    localparam int P_DBG  = 1;
    localparam int DEPTH  = ROM_BYTES / 4;

    logic               p_req    [NPORT];
    logic [ROM_AW-1:0]  p_addr   [NPORT];
    logic [1:0]         p_size   [NPORT];
    logic [PC_W-1:0]    p_pc     [NPORT];
    logic               p_permit [NPORT];
    logic [WORD_AW-1:0] p_idx    [NPORT];
    logic [1:0]         p_lane   [NPORT];
    logic [WORD_W-1:0]  p_word   [NPORT];
    logic [1:0]         lane_q   [NPORT];
    logic [1:0]         size_q   [NPORT];
    logic               valid_q  [NPORT];
    logic [WORD_W-1:0]  p_data   [NPORT];
    logic [WORD_AW-1:0] latch_idx;

    // Gather both request ports into arrays
    always_comb begin
        p_req[P_CPU]  = rd_en & ~rd_we;
        p_addr[P_CPU] = rd_addr;
        p_size[P_CPU] = rd_size;
        p_pc[P_CPU]   = rd_pc;
        p_req[P_DBG]  = dbg_en;
        p_addr[P_DBG] = dbg_addr;
        p_size[P_DBG] = dbg_size;
        p_pc[P_DBG]   = dbg_pc;
    end

    bootrom_store #(
        .DEPTH (DEPTH),
        .IDX_W (WORD_AW),
        .DATA_W(WORD_W),
        .PORTS (NPORT)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_en),
        .fill_idx (fill_idx),
        .fill_word(fill_word),
        .rd_en    (p_req),
        .rd_idx   (p_idx),
        .rd_word  (p_word)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        bootrom_req_decode #(
            .ROM_BYTES(ROM_BYTES),
            .ROM_AW   (ROM_AW),
            .WORD_AW  (WORD_AW)
        ) u_dec (
            .addr     (p_addr[p]),
            .size     (p_size[p]),
            .pc       (p_pc[p]),
            .latch_idx(latch_idx),
            .permit   (p_permit[p]),
            .word_idx (p_idx[p]),
            .lane     (p_lane[p])
        );

        // Keep lane, size and valid of the request alongside the fetched word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q[p]  <= '0;
                size_q[p]  <= '0;
                valid_q[p] <= 1'b0;
            end else begin
                valid_q[p] <= p_req[p];
                if (p_req[p]) begin
                    lane_q[p] <= p_lane[p];
                    size_q[p] <= p_size[p];
                end
            end
        end

        bootrom_lane_fmt u_fmt (
            .word(p_word[p]),
            .lane(lane_q[p]),
            .size(size_q[p]),
            .data(p_data[p])
        );
    end

    // Replay latch: moved only by a permitted requester read
    always_ff @(posedge clk) begin
        if (!rst_n)                             latch_idx <= '0;
        else if (p_req[P_CPU] && p_permit[P_CPU]) latch_idx <= p_idx[P_CPU];
    end

    // Drive the response ports
    always_comb begin
        rd_valid  = valid_q[P_CPU];
        rd_data   = p_data[P_CPU];
        dbg_valid = valid_q[P_DBG];
        dbg_data  = p_data[P_DBG];
    end

endmodule

// File: rtl/bootrom_guard_chk.sv
// Module: protocol checker for the boot ROM read guard, bound to the top.
// Relates request strobes to response timing, width and port agreement.
module bootrom_guard_chk #(
    parameter int ROM_AW = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              rd_we,
    input logic [ROM_AW-1:0] rd_addr,
    input logic [1:0]        rd_size,
    input logic [31:0]       rd_pc,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic              dbg_en,
    input logic [ROM_AW-1:0] dbg_addr,
    input logic [1:0]        dbg_size,
    input logic [31:0]       dbg_pc,
    input logic              dbg_valid,
    input logic [31:0]       dbg_data
);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!rd_valid && !dbg_valid && rd_data == 32'd0)); // R5

    AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !rd_we) |=> rd_valid); // R1

    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n) !(rd_en && !rd_we) |=> !rd_valid); // R8

    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !(rd_en && !rd_we) |=> $stable(rd_data)); // R8

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && rd_we) |=> (!rd_valid && $stable(rd_data))); // R7

    AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !rd_we && rd_size == 2'b00) |=> (rd_data[31:8] == 24'd0)); // R1

    AST_HALF_TRUNC: assert property (@(posedge clk) disable iff (!rst_n) (rd_en && !rd_we && rd_size == 2'b01) |=> (rd_data[31:16] == 16'd0)); // R4

    AST_DBG_VALID: assert property (@(posedge clk) disable iff (!rst_n) dbg_en |=> dbg_valid); // R6

    AST_DBG_MATCHES_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_we && dbg_en && dbg_addr == rd_addr && dbg_size == rd_size && dbg_pc == rd_pc)
        |=> (dbg_data == rd_data)); // R6

endmodule

bind bootrom_guard bootrom_guard_chk #(.ROM_AW(ROM_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_we    (rd_we),
    .rd_addr  (rd_addr),
    .rd_size  (rd_size),
    .rd_pc    (rd_pc),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .dbg_en   (dbg_en),
    .dbg_addr (dbg_addr),
    .dbg_size (dbg_size),
    .dbg_pc   (dbg_pc),
    .dbg_valid(dbg_valid),
    .dbg_data (dbg_data)
);

// File: tb/bootrom_guard_tb_top.sv
// Bench: preloads a computed ROM image, runs directed corner cases and a
// seeded random mix of reads, debug reads and write-flagged requests, and
// compares against a model built from the requirements.
module bootrom_guard_tb_top;

    localparam int ROM_BYTES = 16384;
    localparam int ROM_AW    = 14;
    localparam int WORD_AW   = 12;
    localparam int DEPTH     = 4096;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               fill_en;
    logic [WORD_AW-1:0] fill_idx;
    logic [31:0]        fill_word;
    logic               rd_en, rd_we;
    logic [ROM_AW-1:0]  rd_addr;
    logic [1:0]         rd_size;
    logic [31:0]        rd_pc;
    logic               rd_valid;
    logic [31:0]        rd_data;
    logic               dbg_en;
    logic [ROM_AW-1:0]  dbg_addr;
    logic [1:0]         dbg_size;
    logic [31:0]        dbg_pc;
    logic               dbg_valid;
    logic [31:0]        dbg_data;

    always #5 clk = ~clk;

    bootrom_guard #(.ROM_BYTES(ROM_BYTES)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_word(fill_word),
        .rd_en(rd_en), .rd_we(rd_we), .rd_addr(rd_addr), .rd_size(rd_size), .rd_pc(rd_pc),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dbg_en(dbg_en), .dbg_addr(dbg_addr), .dbg_size(dbg_size), .dbg_pc(dbg_pc),
        .dbg_valid(dbg_valid), .dbg_data(dbg_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [31:0] rom_m [DEPTH];
    int unsigned latch_m = 0;

    function automatic logic [31:0] word_pat(input int i);
        return (i * 32'h9E37_79B1) ^ 32'h5A3C_0F96 ^ (i << 20);
    endfunction

    // Expected response from a word: rotate right by lane bytes, truncate
    function automatic logic [31:0] shape(input logic [31:0] w, input logic [13:0] a, input logic [1:0] sz);
        int sh;
        logic [31:0] r;
        sh = (sz == 2'b00) ? int'(a & 14'd3) : (sz == 2'b01) ? int'(a & 14'd2) : 0;
        r = (sh == 0) ? w : ((w >> (8 * sh)) | (w << (32 - 8 * sh)));
        if (sz == 2'b00) return r & 32'h0000_00FF;
        if (sz == 2'b01) return r & 32'h0000_FFFF;
        return r;
    endfunction

    // Model response; updates the latch only when asked and permitted
    function automatic logic [31:0] model(input logic [13:0] a, input logic [1:0] sz,
                                          input logic [31:0] pc, input bit may_latch);
        logic [31:0] w;
        if (pc < ROM_BYTES) begin
            w = rom_m[a >> 2];
            if (may_latch) latch_m = a >> 2;
        end else begin
            w = rom_m[latch_m];
        end
        return shape(w, a, sz);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cpu_read(input logic [13:0] a, input logic [1:0] sz, input logic [31:0] pc, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        rd_en = 1'b1; rd_we = 1'b0; rd_addr = a; rd_size = sz; rd_pc = pc;
        exp = model(a, sz, pc, 1'b1);
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid === 1'b1, {tag, " valid"}, 32'(rd_valid), 32'd1);
        check(rd_data === exp, {tag, " data"}, rd_data, exp);
    endtask

    task automatic dbg_read(input logic [13:0] a, input logic [1:0] sz, input logic [31:0] pc, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        dbg_en = 1'b1; dbg_addr = a; dbg_size = sz; dbg_pc = pc;
        exp = model(a, sz, pc, 1'b0);
        @(negedge clk);
        dbg_en = 1'b0;
        check(dbg_valid === 1'b1, {tag, " dbg valid"}, 32'(dbg_valid), 32'd1);
        check(dbg_data === exp, {tag, " dbg data"}, dbg_data, exp);
    endtask

    task automatic both_read(input logic [13:0] a, input logic [1:0] sz, input logic [31:0] pc);
        logic [31:0] exp;
        @(negedge clk);
        rd_en = 1'b1; rd_we = 1'b0; rd_addr = a; rd_size = sz; rd_pc = pc;
        dbg_en = 1'b1; dbg_addr = a; dbg_size = sz; dbg_pc = pc;
        exp = model(a, sz, pc, 1'b1);
        @(negedge clk);
        rd_en = 1'b0; dbg_en = 1'b0;
        check(rd_data === exp, "R1/R4 concurrent cpu data", rd_data, exp);
        check(dbg_data === exp, "R6 concurrent dbg data", dbg_data, exp);
    endtask

    task automatic write_req(input logic [13:0] a, input logic [31:0] pc);
        logic [31:0] prev;
        prev = rd_data;
        @(negedge clk);
        rd_en = 1'b1; rd_we = 1'b1; rd_addr = a; rd_size = 2'b10; rd_pc = pc;
        @(negedge clk);
        rd_en = 1'b0; rd_we = 1'b0;
        check(rd_valid === 1'b0, "R7 write gives no valid", 32'(rd_valid), 32'd0);
        check(rd_data === prev, "R7 write leaves data", rd_data, prev);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog
    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; fill_en = 1'b0; fill_idx = '0; fill_word = '0;
        rd_en = 1'b0; rd_we = 1'b0; rd_addr = '0; rd_size = '0; rd_pc = '0;
        dbg_en = 1'b0; dbg_addr = '0; dbg_size = '0; dbg_pc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: reset state
        check(rd_valid === 1'b0, "R5 rd_valid after reset", 32'(rd_valid), 32'd0);
        check(dbg_valid === 1'b0, "R5 dbg_valid after reset", 32'(dbg_valid), 32'd0);
        check(rd_data === 32'd0, "R5 rd_data after reset", rd_data, 32'd0);
        check(dbg_data === 32'd0, "R5 dbg_data after reset", dbg_data, 32'd0);

        // Preload the image
        for (int i = 0; i < DEPTH; i++) begin
            rom_m[i] = word_pat(i);
            fill_en = 1'b1; fill_idx = WORD_AW'(i); fill_word = rom_m[i];
            @(negedge clk);
        end
        fill_en = 1'b0;

        // R5: latch starts at word 0; denied word read replays it
        cpu_read(14'h0010, 2'b10, 32'h0000_4000, "R5 R4 denied word replays word 0");
        // R1: permitted byte at pc boundary 0x3FFF
        cpu_read(14'h0123, 2'b00, 32'h0000_3FFF, "R1 permitted byte pc=3FFF");
        // R4 / R3: denied byte at pc=0x4000 replays latched word, lane 2
        cpu_read(14'h0002, 2'b00, 32'h0000_4000, "R4 R3 denied byte lane 2");
        // R4: denied halfword at odd address uses addr&2
        cpu_read(14'h0003, 2'b01, 32'hFFFF_FFFC, "R4 denied half addr 3");
        cpu_read(14'h0001, 2'b01, 32'h8000_0000, "R4 denied half addr 1");
        // R2: unaligned permitted accesses
        cpu_read(14'h0207, 2'b01, 32'h0000_0100, "R2 permitted half at 0x207");
        cpu_read(14'h030B, 2'b10, 32'h0000_0000, "R2 permitted word at 0x30B");
        cpu_read(14'h3FFF, 2'b11, 32'h0000_2000, "R2 size 11 as word at top");
        cpu_read(14'h3FFD, 2'b00, 32'h0000_1000, "R2 permitted byte at 0x3FFD");
        cpu_read(14'h0006, 2'b10, 32'h0001_0000, "R4 R3 denied word unrotated");
        // R7: write request ignored; latch and contents unchanged
        write_req(14'h0040, 32'h0000_0000);
        cpu_read(14'h0001, 2'b00, 32'h0000_5000, "R7 latch kept after write");
        cpu_read(14'h0040, 2'b10, 32'h0000_0000, "R7 rom unchanged after write");
        // R6: debug reads never move the latch
        dbg_read(14'h0400, 2'b10, 32'h0000_0004, "R6 permitted");
        dbg_read(14'h0002, 2'b01, 32'h0000_9000, "R6 denied");
        cpu_read(14'h0003, 2'b00, 32'h0000_9000, "R6 latch kept after dbg");
        both_read(14'h1235, 2'b00, 32'h0000_0010);
        both_read(14'h0006, 2'b01, 32'h0000_7000);
        // R8: data holds through idle cycles
        hold = rd_data;
        repeat (3) @(negedge clk);
        check(rd_valid === 1'b0, "R8 valid drops when idle", 32'(rd_valid), 32'd0);
        check(rd_data === hold, "R8 data holds when idle", rd_data, hold);

        // Random mix
        for (int k = 0; k < 2000; k++) begin
            logic [13:0] a;
            logic [1:0]  sz;
            logic [31:0] pc;
            int sel;
            int kind;
            a = 14'($urandom % ROM_BYTES);
            sz = 2'($urandom % 4);
            sel = $urandom % 4;
            pc = (sel == 0) ? ($urandom % ROM_BYTES) :
                 (sel == 1) ? (32'h4000 + ($urandom % 65536)) :
                 (sel == 2) ? ($urandom | 32'h8000_0000) : 32'h0000_3FF0;
            kind = $urandom % 8;
            if (kind == 0)      dbg_read(a, sz, pc, "R6 random");
            else if (kind == 1) both_read(a, sz, pc);
            else if (kind == 2) write_req(a, pc);
            else if (pc < ROM_BYTES) cpu_read(a, sz, pc, "R1 random permitted");
            else                cpu_read(a, sz, pc, "R4 random denied");
        end

        finished = 1;
        report();
        $finish;
    end

endmodule